// File: doc/BRIEF.md
# UART Host Register File

This block is the host-facing register set of a 16550-compatible serial port. A byte-wide bus with a 3-bit offset and separate read and write strobes reaches eight locations. Behind them sit the baud divisor, the interrupt enables, the FIFO setup, the line and modem control bytes and a scratch byte. The serial shifters, the baud generator and the FIFO storage live outside this block. They exchange data with it through single-cycle strobes and level status inputs, and they take from it the divisor, the line settings, the FIFO clears and the receive trigger level.

Bit 7 of the line control byte switches offsets 0 and 1 between the data and interrupt-enable registers and the two divisor bytes. Several status bits clear as a side effect of reading them. The FIFO control byte is write-only: it keeps only part of what is written, and it ignores a write that repeats the stored value. The block ranks five interrupt sources, drives a single interrupt line, and returns the code of the highest-ranked pending source through the identification register.

Top module: `uart_host_regs`

## Requirements
- R1: After reset the offsets read IER 0x00, IIR 0x01, LCR 0x00, MCR 0x08, LSR 0x60 (with rx_count 0) and scratch 0x00. `divisor` is 0x000C, `rx_trig` is 1, `fifo_en` is 0 and `irq` is 0.
- R2: While LCR bit 7 is 1, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. The `divisor` output follows from the next cycle.
- R3: While LCR bit 7 is 0, a write to offset 0 raises `tx_push` for that cycle with `tx_data` equal to the written byte. A read of offset 0 returns `rx_data` and raises `rx_pop` in that cycle only when rx_count is nonzero.
- R4: A write to offset 1 with LCR bit 7 clear stores bits 3:0 as the interrupt enables (bit 0 receive, bit 1 transmit empty, bit 2 line status, bit 3 modem status), and bits 7:4 read back as 0. If THRE is set at that write, a transmit-empty interrupt becomes pending.
- R5: A write to offset 2 (FIFO control) that equals the stored value has no effect. Any other write stores the written byte masked with 0xC9. It pulses `rx_flush` when bit 1 is set and `tx_flush` when bit 2 is set, and it pulses both when bit 0 (FIFO enable) changes. The pulses come in the write cycle.
- R6: Stored FIFO-control bits 7:6 select `rx_trig`: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14.
- R7: IIR bits 7:6 read 11 while the FIFOs are enabled and 00 otherwise. Bits 5:4 read 0.
- R8: LCR (offset 3) and scratch (offset 7) store all 8 bits. MCR (offset 4) stores bits 4:0. Writes to offsets 5 and 6 change nothing.
- R9: LSR is {0, TEMT, THRE, BI, FE, PE, OE, DR} with DR = (rx_count != 0). A data write clears THRE and also clears TEMT when the FIFOs are enabled, and it cancels a pending transmit-empty interrupt. `tx_hold_free` sets THRE and makes a transmit-empty interrupt pending. `tx_shift_done` sets TEMT.
- R10: Reading the IIR cancels the pending transmit-empty interrupt. Reading the LSR clears BI, FE, PE and OE, which the pulses `rx_break`, `rx_frame_err`, `rx_parity_err` and `rx_overrun` set.
- R11: IIR bits 3:0 give the highest-ranked enabled pending source. The codes are 0x6 for a line error, 0x4 for receive data, 0xC for a receive timeout, 0x2 for transmit empty and 0x0 for modem status, with 0x1 when none is pending. Receive data is pending when rx_count ≥ `rx_trig` in FIFO mode, or when rx_count ≠ 0 otherwise. Modem status is pending when any of `msr_in` bits 3:0 is set and MCR bit 4 is clear. `irq` is 1 exactly when a source is pending.
- R12: With MCR bit 4 (loopback) set, offset 6 reads {MCR[3], MCR[2], MCR[0], MCR[1], 0000}. Otherwise it reads `msr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| tx_data | output | 8 | Byte handed to the transmit path |
| tx_push | output | 1 | Transmit byte strobe |
| rx_data | input | 8 | Head byte of the receive path |
| rx_count | input | CNT_W | Bytes held in the receive path |
| rx_pop | output | 1 | Receive byte consumed |
| rx_timeout | input | 1 | Receive timeout condition |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity_err | input | 1 | Parity error event pulse |
| rx_frame_err | input | 1 | Framing error event pulse |
| rx_break | input | 1 | Break event pulse |
| tx_hold_free | input | 1 | Holding register emptied |
| tx_shift_done | input | 1 | Transmitter fully idle |
| msr_in | input | 8 | Modem status from the line side |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| modem_ctrl | output | 5 | Modem control bits |
| fifo_en | output | 1 | FIFO mode enabled |
| rx_trig | output | CNT_W | Receive trigger level |
| rx_flush | output | 1 | Receive FIFO clear pulse |
| tx_flush | output | 1 | Transmit FIFO clear pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, that `irq` agrees with the identification code, that the trigger level stays within the four legal values, and that a FIFO-enable change forces both clear pulses. They also check the cycle-after effects of a bus access: the divisor and enable registers take the written value, a data write drops THRE, and an LSR read drops BI. The bench's scenarios are needed for what depends on history. These are the masking of the FIFO control byte, the ignored repeat write, the masked writes and the ignored offsets, the THRE and TEMT sequencing in each mode, and the read-clear of the transmit-empty interrupt. The same holds for the ranking of sources under many random mixes of enables, errors, fill levels and trigger settings, and for the loopback bit shuffle.

// File: rtl/uart_host_pkg.sv
package uart_host_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IIR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [7:0] FCR_KEEP = 8'hC9;
    localparam logic [3:0] IID_NONE = 4'h1;

    // interrupt sources, index 0 ranks highest
    localparam int NSRC    = 5;
    localparam int SRC_LS  = 0;
    localparam int SRC_RX  = 1;
    localparam int SRC_TO  = 2;
    localparam int SRC_THR = 3;
    localparam int SRC_MS  = 4;

    function automatic logic [3:0] iid_code(int idx);
        case (idx)
            SRC_LS:  return 4'h6;
            SRC_RX:  return 4'h4;
            SRC_TO:  return 4'hC;
            SRC_THR: return 4'h2;
            default: return 4'h0;
        endcase
    endfunction

    typedef struct packed {
        logic [15:0] div;
        logic [3:0]  ier;
        logic [7:0]  lcr;
        logic [4:0]  mcr;
        logic [7:0]  scr;
        logic        thre;
        logic        temt;
        logic        thr_ip;
        logic        oe;
        logic        pe;
        logic        fe;
        logic        bi;
    } host_state_t;

endpackage

// File: rtl/uart_fcr_ctrl.sv
module uart_fcr_ctrl
    import uart_host_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int TRIG0 = 1,
    parameter int TRIG1 = 4,
    parameter int TRIG2 = 8,
    parameter int TRIG3 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    output logic             fifo_en,
    output logic [CNT_W-1:0] rx_trig,
    output logic             rx_flush,
    output logic             tx_flush
);

    logic [7:0] fcr_d, fcr_q;
    logic       changed;
    logic       toggled;

    always_comb begin
        fcr_d    = fcr_q;
        changed  = wr_en && (wdata != fcr_q);
        toggled  = changed && (wdata[0] != fcr_q[0]);
        rx_flush = 1'b0;
        tx_flush = 1'b0;
        if (changed) begin
            fcr_d    = wdata & FCR_KEEP;
            rx_flush = wdata[1] | toggled;
            tx_flush = wdata[2] | toggled;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcr_q <= 8'h00;
        else        fcr_q <= fcr_d;
    end

    always_comb begin
        case (fcr_q[7:6])
            2'b00:   rx_trig = CNT_W'(TRIG0);
            2'b01:   rx_trig = CNT_W'(TRIG1);
            2'b10:   rx_trig = CNT_W'(TRIG2);
            default: rx_trig = CNT_W'(TRIG3);
        endcase
    end

    assign fifo_en = fcr_q[0];

    // R5
    flush_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[0] != fifo_en)) |-> (rx_flush && tx_flush));

    // R5
    fe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[0] != fifo_en)) |=> (fifo_en == $past(wdata[0])));

    // R6
    trig_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_trig == CNT_W'(TRIG0)) || (rx_trig == CNT_W'(TRIG1)) ||
        (rx_trig == CNT_W'(TRIG2)) || (rx_trig == CNT_W'(TRIG3)));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_host_pkg::*;
(
    input  logic [NSRC-1:0] src,
    output logic [3:0]      iid,
    output logic            any
);

    always_comb begin
        iid = IID_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (src[i]) iid = iid_code(i);
        end
        any = |src;
    end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uart_host_pkg::*;
#(
    parameter int          FIFO_DEPTH = 16,
    parameter logic [15:0] DIV_RST    = 16'h000C,
    parameter logic [4:0]  MCR_RST    = 5'h08,
    localparam int         CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [7:0]       tx_data,
    output logic             tx_push,
    input  logic [7:0]       rx_data,
    input  logic [CNT_W-1:0] rx_count,
    output logic             rx_pop,
    input  logic             rx_timeout,
    input  logic             rx_overrun,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             rx_break,
    input  logic             tx_hold_free,
    input  logic             tx_shift_done,
    input  logic [7:0]       msr_in,
    output logic [15:0]      divisor,
    output logic [7:0]       line_ctrl,
    output logic [4:0]       modem_ctrl,
    output logic             fifo_en,
    output logic [CNT_W-1:0] rx_trig,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             irq
);

    host_state_t st_d, st_q;

    logic            dlab;
    logic [7:0]      wr_hit;
    logic [7:0]      rd_hit;
    logic [NSRC-1:0] src;
    logic [3:0]      iid;
    logic            any_pend;
    logic            rx_avail;
    logic            rx_at_level;
    logic [7:0]      lsr_val;
    logic [7:0]      msr_val;

    assign dlab = st_q.lcr[7];

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            wr_hit[k] = bus_wr && (bus_addr == 3'(k));
            rd_hit[k] = bus_rd && (bus_addr == 3'(k));
        end
    end

    uart_fcr_ctrl #(
        .CNT_W (CNT_W)
    ) u_fcr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_hit[OFS_IIR]),
        .wdata    (bus_wdata),
        .fifo_en  (fifo_en),
        .rx_trig  (rx_trig),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    // next state: bus effects first, datapath events override
    always_comb begin
        st_d = st_q;
        if (wr_hit[OFS_DATA]) begin
            if (dlab) begin
                st_d.div[7:0] = bus_wdata;
            end else begin
                st_d.thre   = 1'b0;
                st_d.thr_ip = 1'b0;
                if (fifo_en) st_d.temt = 1'b0;
            end
        end
        if (wr_hit[OFS_IER]) begin
            if (dlab) begin
                st_d.div[15:8] = bus_wdata;
            end else begin
                st_d.ier = bus_wdata[3:0];
                if (st_q.thre) st_d.thr_ip = 1'b1;
            end
        end
        if (wr_hit[OFS_LCR]) st_d.lcr = bus_wdata;
        if (wr_hit[OFS_MCR]) st_d.mcr = bus_wdata[4:0];
        if (wr_hit[OFS_SCR]) st_d.scr = bus_wdata;
        if (rd_hit[OFS_IIR]) st_d.thr_ip = 1'b0;
        if (rd_hit[OFS_LSR]) begin
            st_d.oe = 1'b0;
            st_d.pe = 1'b0;
            st_d.fe = 1'b0;
            st_d.bi = 1'b0;
        end
        if (tx_hold_free) begin
            st_d.thre   = 1'b1;
            st_d.thr_ip = 1'b1;
        end
        if (tx_shift_done) st_d.temt = 1'b1;
        if (rx_overrun)    st_d.oe   = 1'b1;
        if (rx_parity_err) st_d.pe   = 1'b1;
        if (rx_frame_err)  st_d.fe   = 1'b1;
        if (rx_break)      st_d.bi   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.div    <= DIV_RST;
            st_q.mcr    <= MCR_RST;
            st_q.thre   <= 1'b1;
            st_q.temt   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // interrupt sources
    assign rx_avail    = (rx_count != '0);
    assign rx_at_level = fifo_en ? (rx_count >= rx_trig) : rx_avail;

    always_comb begin
        src          = '0;
        src[SRC_LS]  = st_q.ier[2] & (st_q.oe | st_q.pe | st_q.fe | st_q.bi);
        src[SRC_RX]  = st_q.ier[0] & rx_at_level;
        src[SRC_TO]  = st_q.ier[0] & rx_timeout;
        src[SRC_THR] = st_q.ier[1] & st_q.thr_ip;
        src[SRC_MS]  = st_q.ier[3] & ~st_q.mcr[4] & (|msr_in[3:0]);
    end

    uart_irq_prio u_prio (
        .src (src),
        .iid (iid),
        .any (any_pend)
    );

    // read path
    assign lsr_val = {1'b0, st_q.temt, st_q.thre, st_q.bi,
                      st_q.fe, st_q.pe, st_q.oe, rx_avail};
    assign msr_val = st_q.mcr[4] ?
                     {st_q.mcr[3], st_q.mcr[2], st_q.mcr[0], st_q.mcr[1], 4'b0000} :
                     msr_in;

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = dlab ? st_q.div[7:0]  : rx_data;
            OFS_IER:  bus_rdata = dlab ? st_q.div[15:8] : {4'b0000, st_q.ier};
            OFS_IIR:  bus_rdata = {fifo_en, fifo_en, 2'b00, iid};
            OFS_LCR:  bus_rdata = st_q.lcr;
            OFS_MCR:  bus_rdata = {3'b000, st_q.mcr};
            OFS_LSR:  bus_rdata = lsr_val;
            OFS_MSR:  bus_rdata = msr_val;
            default:  bus_rdata = st_q.scr;
        endcase
    end

    assign tx_data    = bus_wdata;
    assign tx_push    = wr_hit[OFS_DATA] & ~dlab;
    assign rx_pop     = rd_hit[OFS_DATA] & ~dlab & rx_avail;
    assign divisor    = st_q.div;
    assign line_ctrl  = st_q.lcr;
    assign modem_ctrl = st_q.mcr;
    assign irq        = any_pend;

    // R11
    irq_iid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid != IID_NONE));

    // R2
    div_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[OFS_DATA] && dlab) |=> (divisor[7:0] == $past(bus_wdata)));

    // R4
    ier_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit[OFS_IER] && !dlab) |=> (st_q.ier == $past(bus_wdata[3:0])));

    // R9
    thre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !tx_hold_free) |=> !lsr_val[5]);

    // R10
    bi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit[OFS_LSR] && !rx_break) |=> !lsr_val[4]);

endmodule

// File: tb/uart_host_regs_tb.sv
module uart_host_regs_tb;

    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [7:0]       tx_data;
    logic             tx_push;
    logic [7:0]       rx_data = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             rx_pop;
    logic             rx_timeout = 1'b0;
    logic             rx_overrun = 1'b0;
    logic             rx_parity_err = 1'b0;
    logic             rx_frame_err = 1'b0;
    logic             rx_break = 1'b0;
    logic             tx_hold_free = 1'b0;
    logic             tx_shift_done = 1'b0;
    logic [7:0]       msr_in = '0;
    logic [15:0]      divisor;
    logic [7:0]       line_ctrl;
    logic [4:0]       modem_ctrl;
    logic             fifo_en;
    logic [CNT_W-1:0] rx_trig;
    logic             rx_flush;
    logic             tx_flush;
    logic             irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    uart_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_push(tx_push), .rx_data(rx_data),
        .rx_count(rx_count), .rx_pop(rx_pop), .rx_timeout(rx_timeout),
        .rx_overrun(rx_overrun), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break),
        .tx_hold_free(tx_hold_free), .tx_shift_done(tx_shift_done),
        .msr_in(msr_in), .divisor(divisor), .line_ctrl(line_ctrl),
        .modem_ctrl(modem_ctrl), .fifo_en(fifo_en), .rx_trig(rx_trig),
        .rx_flush(rx_flush), .tx_flush(tx_flush), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input logic [2:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        bus_read(a, v);
        check(v == exp, req, v, exp);
    endtask

    task automatic fcr_write_check(input logic [7:0] d, input bit exp_rx, input bit exp_tx);
        @(negedge clk);
        bus_addr = 3'd2; bus_wdata = d; bus_wr = 1'b1;
        #1 check(rx_flush == exp_rx, "R5 rx_flush", rx_flush, exp_rx);
        check(tx_flush == exp_tx, "R5 tx_flush", tx_flush, exp_tx);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_hold_free();
        @(negedge clk); tx_hold_free = 1'b1;
        @(negedge clk); tx_hold_free = 1'b0;
    endtask

    task automatic pulse_shift_done();
        @(negedge clk); tx_shift_done = 1'b1;
        @(negedge clk); tx_shift_done = 1'b0;
    endtask

    function automatic int trig_of(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [3:0] exp_iid(input logic [3:0] ier, input bit ls, input bit rxd,
                                           input bit to, input bit thr, input bit ms);
        if (ier[2] && ls)  return 4'h6;
        if (ier[0] && rxd) return 4'h4;
        if (ier[0] && to)  return 4'hC;
        if (ier[1] && thr) return 4'h2;
        if (ier[3] && ms)  return 4'h0;
        return 4'h1;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(divisor == 16'h000C, "R1 divisor", divisor, 16'h000C);
        check(rx_trig == 1, "R1 rx_trig", rx_trig, 1);
        check(fifo_en == 0, "R1 fifo_en", fifo_en, 0);
        check(irq == 0, "R1 irq", irq, 0);
        read_check(3'd1, 8'h00, "R1 IER");
        read_check(3'd2, 8'h01, "R1 IIR");
        read_check(3'd3, 8'h00, "R1 LCR");
        read_check(3'd4, 8'h08, "R1 MCR");
        read_check(3'd5, 8'h60, "R1 LSR");
        read_check(3'd7, 8'h00, "R1 SCR");

        // R8 scratch, LCR, MCR masking, ignored offsets
        for (int i = 0; i < 20; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            bus_write(3'd7, r);
            read_check(3'd7, r, "R8 scratch");
            r = 8'($urandom) & 8'h7F;
            bus_write(3'd3, r);
            read_check(3'd3, r, "R8 LCR");
            check(line_ctrl == r, "R8 line_ctrl", line_ctrl, r);
            r = 8'($urandom) & 8'hEF;
            bus_write(3'd4, r);
            read_check(3'd4, {3'b000, r[4:0]}, "R8 MCR low bits");
        end
        bus_write(3'd3, 8'h00);
        bus_write(3'd4, 8'h08);
        msr_in = 8'hB0;
        bus_write(3'd5, 8'hFF);
        bus_write(3'd6, 8'h0F);
        read_check(3'd5, 8'h60, "R8 LSR write ignored");
        read_check(3'd6, 8'hB0, "R8 MSR write ignored");
        msr_in = 8'h00;

        // R2 divisor access
        bus_write(3'd3, 8'h80);
        for (int i = 0; i < 8; i++) begin
            logic [15:0] dv;
            dv = 16'($urandom);
            bus_write(3'd0, dv[7:0]);
            bus_write(3'd1, dv[15:8]);
            check(divisor == dv, "R2 divisor out", divisor, dv);
            read_check(3'd0, dv[7:0], "R2 divisor low");
            read_check(3'd1, dv[15:8], "R2 divisor high");
        end
        bus_write(3'd3, 8'h00);
        read_check(3'd1, 8'h00, "R2 offset1 is IER when clear");

        // R3 data path strobes
        @(negedge clk);
        bus_addr = 3'd0; bus_wdata = 8'h5A; bus_wr = 1'b1;
        #1 check(tx_push && tx_data == 8'h5A, "R3 tx_push/tx_data", {tx_push, tx_data}, 9'h15A);
        @(negedge clk); bus_wr = 1'b0;
        pulse_hold_free();
        pulse_shift_done();
        bus_read(3'd2, v);
        rx_count = 5'd3; rx_data = 8'hA7;
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1;
        #1 check(bus_rdata == 8'hA7, "R3 rx data read", bus_rdata, 8'hA7);
        check(rx_pop == 1, "R3 rx_pop", rx_pop, 1);
        @(negedge clk); bus_rd = 1'b0;
        rx_count = 5'd0;
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1;
        #1 check(rx_pop == 0, "R3 no pop when empty", rx_pop, 0);
        @(negedge clk); bus_rd = 1'b0;

        // R4 IER masking and transmit-empty pending
        bus_write(3'd1, 8'hF2);
        read_check(3'd1, 8'h02, "R4 IER low nibble");
        check(irq == 1, "R4 irq after IER write", irq, 1);
        read_check(3'd2, 8'h02, "R4 IIR thr pending");
        read_check(3'd2, 8'h01, "R10 IIR read clears thr");
        check(irq == 0, "R10 irq after IIR read", irq, 0);

        // R9 non-FIFO data write
        bus_write(3'd1, 8'h02);
        bus_write(3'd0, 8'h11);
        read_check(3'd5, 8'h40, "R9 non-fifo clears THRE only");
        read_check(3'd2, 8'h01, "R9 write cancels thr pending");
        pulse_hold_free();
        read_check(3'd5, 8'h60, "R9 hold_free sets THRE");
        read_check(3'd2, 8'h02, "R9 hold_free pends thr");

        // R5 R6 R7 FIFO control
        fcr_write_check(8'h01, 1, 1);
        check(fifo_en == 1, "R5 fifo_en on", fifo_en, 1);
        read_check(3'd2, 8'hC1, "R7 IIR fifo bits");
        fcr_write_check(8'h01, 0, 0);
        fcr_write_check(8'h03, 1, 0);
        fcr_write_check(8'h05, 0, 1);
        fcr_write_check(8'h41, 0, 0);
        check(rx_trig == 4, "R6 trig 01", rx_trig, 4);
        fcr_write_check(8'h81, 0, 0);
        check(rx_trig == 8, "R6 trig 10", rx_trig, 8);
        fcr_write_check(8'hF7, 1, 1);
        check(rx_trig == 14, "R6 trig 11", rx_trig, 14);
        fcr_write_check(8'hC1, 0, 0);
        fcr_write_check(8'hC1, 0, 0);

        // R9 FIFO-mode data write
        bus_write(3'd0, 8'h22);
        read_check(3'd5, 8'h00, "R9 fifo clears THRE and TEMT");
        pulse_hold_free();
        read_check(3'd5, 8'h20, "R9 THRE back");
        pulse_shift_done();
        read_check(3'd5, 8'h60, "R9 TEMT back");
        fcr_write_check(8'h00, 1, 1);
        check(fifo_en == 0, "R5 fifo_en off", fifo_en, 0);
        read_check(3'd2, 8'h02, "R7 IIR fifo bits cleared");

        // R10 break and error clearing
        @(negedge clk); rx_break = 1'b1; rx_parity_err = 1'b1;
        @(negedge clk); rx_break = 1'b0; rx_parity_err = 1'b0;
        read_check(3'd5, 8'h74, "R10 LSR shows BI and PE");
        read_check(3'd5, 8'h60, "R10 LSR read clears BI and PE");

        // R12 loopback
        bus_write(3'd4, 8'h13);
        read_check(3'd6, 8'h30, "R12 loopback low bits");
        bus_write(3'd4, 8'h1C);
        read_check(3'd6, 8'hC0, "R12 loopback high bits");
        bus_write(3'd4, 8'h08);

        // R11 random priority mixes
        for (int it = 0; it < 150; it++) begin
            logic [7:0] fcr_v;
            logic [3:0] ier_v;
            logic [3:0] exp_code;
            int         err_sel;
            bit         thr_v;
            bit         rxd;
            logic [7:0] exp_rd;
            fcr_v = {2'($urandom), 5'b00000, 1'($urandom)};
            bus_write(3'd2, fcr_v);
            bus_read(3'd5, v);
            bus_read(3'd2, v);
            ier_v = 4'($urandom);
            bus_write(3'd1, {4'b0000, ier_v});
            thr_v = 1'b1;
            if ($urandom % 2) begin
                bus_read(3'd2, v);
                thr_v = 1'b0;
            end
            err_sel = $urandom % 5;
            @(negedge clk);
            rx_overrun    = (err_sel == 1);
            rx_parity_err = (err_sel == 2);
            rx_frame_err  = (err_sel == 3);
            rx_break      = (err_sel == 4);
            @(negedge clk);
            rx_overrun = 0; rx_parity_err = 0; rx_frame_err = 0; rx_break = 0;
            rx_count   = 5'($urandom % 17);
            rx_timeout = 1'($urandom);
            msr_in     = 8'($urandom);
            rxd = fcr_v[0] ? (int'(rx_count) >= trig_of(fcr_v[7:6])) : (rx_count != 0);
            exp_code = exp_iid(ier_v, err_sel != 0, rxd, rx_timeout, thr_v, |msr_in[3:0]);
            exp_rd = {fcr_v[0], fcr_v[0], 2'b00, exp_code};
            #1 check(irq == (exp_code != 4'h1), "R11 irq", irq, exp_code != 4'h1);
            read_check(3'd2, exp_rd, "R11 IIR priority");
        end
        rx_count = 0; rx_timeout = 0; msr_in = 0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule